// File: doc/BRIEF.md
# Three-Phase Inverter Protection Supervisor

This block sits between the already filtered PWM commands of a three-phase inverter and its six gate-drive outputs. Each phase has one high-side and one low-side command. The block resolves them against a set of protection flags and drives the six outputs. The flags are an over-current trip, a DC-bus over-voltage flag, a logic-supply undervoltage flag, three per-phase floating-supply undervoltage flags and an enable input. Every flag arrives as a clean, synchronous digital level. Analog comparison, hysteresis, input filtering and deadtime generation are handled elsewhere.

A trip or a logic-supply undervoltage removes drive from all six outputs and pulls the fault line low. After a qualified trip ends, the block holds the fault for a programmable number of clock cycles, which takes the place of the RC timer found on analog drivers. A DC-bus over-voltage applies zero-vector braking instead of a shutdown: all low sides turn on and all high sides turn off, and no fault is raised. The fault line is modelled as an open-drain pin: an active-low level together with an output-enable.

All outputs are registered. A change on any input appears at the outputs one clock edge after it is sampled. The only exception is the trip, which must first pass its blanking window. The interface has no data stream, so every pin is a plain level and none has valid/ready back-pressure.

Top module: `inv_prot_sup`

## Requirements
- R1: Once a trip is qualified, all six outputs go low and flt_n goes low at the next edge.
- R2: When a qualified trip ends, the fault and the shutdown stay in force for clr_delay+2 further cycles. The count is taken from the first edge at which trip_in is seen low, and counting starts only once neither the trip nor the logic-supply undervoltage is present.
- R3: While vcc_uv is 1, all outputs are 0 and flt_n is 0. This is not latched: the cycle after vcc_uv clears, normal drive and flt_n=1 return.
- R4: While dcbus_ov is 1 and no shutdown is active, lo_out=3'b111 and hi_out=3'b000 with flt_n=1. This holds even when every command is 0 or en is 0, and it ends as soon as the flag clears.
- R5: In normal operation, with en=1 and no flags set, hi_out[i] follows hi_cmd[i] and lo_out[i] follows lo_cmd[i] with one cycle of latency. Bit i is phase i.
- R6: With en=0 and no braking, all six outputs are 0. en does not affect flt_n and is not latched.
- R7: vbs_uv[i]=1 forces hi_out[i] to 0 and leaves the other phases alone. After the flag clears, hi_out[i] stays 0 until hi_cmd[i] has been seen 0 and then 1 (a fresh rising edge).
- R8: If hi_cmd[i] and lo_cmd[i] are both 1, both outputs of phase i are 0. A phase never has both outputs at 1.
- R9: A trip_in pulse shorter than BLANK_CYC consecutive cycles is ignored. A trip held for BLANK_CYC cycles takes effect on the outputs at the next edge after those cycles.
- R10: Priority, from highest to lowest: shutdown (trip, trip hold, vcc_uv), then braking, then enable, then the PWM commands.
- R11: flt_oe is 1 exactly when flt_n is 0. After reset flt_n=1 and flt_oe=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 3 | High-side PWM commands, bit i = phase i |
| lo_cmd | input | 3 | Low-side PWM commands, bit i = phase i |
| en | input | 1 | Drive enable, active high |
| trip_in | input | 1 | Over-current / over-temperature trip flag |
| dcbus_ov | input | 1 | DC-bus over-voltage flag |
| vcc_uv | input | 1 | Logic-supply undervoltage flag |
| vbs_uv | input | 3 | Per-phase floating-supply undervoltage flags |
| clr_delay | input | 16 | Fault hold length in cycles |
| hi_out | output | 3 | High-side gate drive |
| lo_out | output | 3 | Low-side gate drive |
| flt_n | output | 1 | Fault level, active low |
| flt_oe | output | 1 | Fault pin drive enable (open-drain model) |

## Verification
The properties assume that every flag and command is a synchronous level, sampled once per rising edge and free of glitches. They also assume that clr_delay stays stable while a fault is held. The braking property compares the outputs with the flag from the previous edge, so the checker keeps its own record of whether a clocked edge has passed since reset. The bench changes inputs only on the falling edge, holds clr_delay constant, and keeps every flag low across the reset release, so each property sees legal history.

// File: rtl/inv_sup_pkg.sv
package inv_sup_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_t;

  localparam leg_t LEG_OFF   = '{hi: 1'b0, lo: 1'b0};
  localparam leg_t LEG_BRAKE = '{hi: 1'b0, lo: 1'b1};
endpackage

// File: rtl/trip_blanker.sv
module trip_blanker #(
  parameter int BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_raw,
  output logic trip_act
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(BLANK_CYC);

  logic [CW-1:0] run_cnt;

  // counts consecutive active cycles, saturating at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (!trip_raw)
      run_cnt <= '0;
    else if (run_cnt != LIM)
      run_cnt <= run_cnt + 1'b1;
  end

  assign trip_act = (run_cnt == LIM);
endmodule

// File: rtl/fault_hold_timer.sv
module fault_hold_timer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_act,
  input  logic          uv,
  input  logic [DW-1:0] clr_delay,
  output logic          shut
);
  logic [DW-1:0] remain;
  logic          hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      hold   <= 1'b0;
    end else if (trip_act || uv) begin
      remain <= clr_delay;
      if (trip_act) hold <= 1'b1;
    end else if (hold) begin
      if (remain == '0) hold <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign shut = trip_act | uv | hold;
endmodule

// File: rtl/phase_arbiter.sv
module phase_arbiter
  import inv_sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hc,
  input  logic lc,
  input  logic bs_uv,
  input  logic shut,
  input  logic brake,
  input  logic en,
  output leg_t drv
);
  logic hc_prev, blk, rise, lock;
  leg_t nxt;

  assign rise = hc & ~hc_prev;
  assign lock = bs_uv | (blk & ~rise);

  always_comb begin
    if (shut)       nxt = LEG_OFF;
    else if (brake) nxt = LEG_BRAKE;
    else if (!en)   nxt = LEG_OFF;
    else begin
      nxt.hi = hc & ~lc & ~lock;
      nxt.lo = lc & ~hc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_prev <= 1'b0;
      blk     <= 1'b0;
      drv     <= LEG_OFF;
    end else begin
      hc_prev <= hc;
      blk     <= lock;
      drv     <= nxt;
    end
  end
endmodule

// File: rtl/inv_prot_sup.sv
module inv_prot_sup
  import inv_sup_pkg::*;
#(
  parameter int PHASES    = 3,
  parameter int BLANK_CYC = 4,
  parameter int DLY_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hi_cmd,
  input  logic [PHASES-1:0] lo_cmd,
  input  logic              en,
  input  logic              trip_in,
  input  logic              dcbus_ov,
  input  logic              vcc_uv,
  input  logic [PHASES-1:0] vbs_uv,
  input  logic [DLY_W-1:0]  clr_delay,
  output logic [PHASES-1:0] hi_out,
  output logic [PHASES-1:0] lo_out,
  output logic              flt_n,
  output logic              flt_oe
);
  logic trip_act, shut;

  trip_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .trip_raw(trip_in), .trip_act(trip_act)
  );

  fault_hold_timer #(.DW(DLY_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .trip_act(trip_act), .uv(vcc_uv),
    .clr_delay(clr_delay), .shut(shut)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_ph
    leg_t d;
    phase_arbiter u_arb (
      .clk(clk), .rst_n(rst_n), .hc(hi_cmd[p]), .lc(lo_cmd[p]),
      .bs_uv(vbs_uv[p]), .shut(shut), .brake(dcbus_ov), .en(en), .drv(d)
    );
    assign hi_out[p] = d.hi;
    assign lo_out[p] = d.lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_n  <= 1'b1;
      flt_oe <= 1'b0;
    end else begin
      flt_n  <= ~shut;
      flt_oe <= shut;
    end
  end
endmodule

// File: rtl/inv_prot_sup_chk.sv
module inv_prot_sup_chk #(
  parameter int PHASES = 3,
  parameter int DLY_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PHASES-1:0] hi_cmd,
  input logic [PHASES-1:0] lo_cmd,
  input logic              en,
  input logic              trip_in,
  input logic              dcbus_ov,
  input logic              vcc_uv,
  input logic [PHASES-1:0] vbs_uv,
  input logic [DLY_W-1:0]  clr_delay,
  input logic [PHASES-1:0] hi_out,
  input logic [PHASES-1:0] lo_out,
  input logic              flt_n,
  input logic              flt_oe
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_n |-> (hi_out == '0 && lo_out == '0));

  p_uv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_uv |=> (hi_out == '0 && lo_out == '0 && !flt_n));

  p_brake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && flt_n && $past(dcbus_ov)) |-> (lo_out == '1 && hi_out == '0));

  p_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !dcbus_ov) |=> (hi_out == '0 && lo_out == '0));

  p_shoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_out & lo_out) == '0);

  p_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flt_oe != flt_n);

  for (genvar p = 0; p < PHASES; p++) begin : g_bs
    p_bs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vbs_uv[p] |=> !hi_out[p]);
  end
endmodule

bind inv_prot_sup inv_prot_sup_chk #(.PHASES(PHASES), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/sim_inv_prot_sup.sv
module sim_inv_prot_sup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hi_cmd = '0, lo_cmd = '0, vbs_uv = '0;
  logic en = 1'b0, trip_in = 1'b0, dcbus_ov = 1'b0, vcc_uv = 1'b0;
  logic [15:0] clr_delay = 16'd10;
  logic [2:0] hi_out, lo_out;
  logic flt_n, flt_oe;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // scoreboard queues
  int         q_cyc[$];
  logic [6:0] q_val[$];
  string      q_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  inv_prot_sup u0 (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .en(en),
    .trip_in(trip_in), .dcbus_ov(dcbus_ov), .vcc_uv(vcc_uv), .vbs_uv(vbs_uv),
    .clr_delay(clr_delay), .hi_out(hi_out), .lo_out(lo_out),
    .flt_n(flt_n), .flt_oe(flt_oe)
  );

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got hi=%b lo=%b fn=%b, expected hi=%b lo=%b fn=%b",
               tag, act[6:4], act[3:1], act[0], exp[6:4], exp[3:1], exp[0]);
    end
  endtask

  // monitor: compares the result of each driven vector one edge later
  always @(negedge clk) begin
    if (rst_n && q_cyc.size() > 0 && q_cyc[0] < cyc) begin
      logic [6:0] e;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      void'(q_cyc.pop_front());
      chk(t, {hi_out, lo_out, flt_n}, e);
      checks++;
      if (flt_oe !== ~flt_n) begin
        errors++;
        $display("FAIL R11: flt_oe=%b expected %b", flt_oe, ~flt_n);
      end
    end
  end

  task automatic step(input logic [2:0] h, input logic [2:0] l, input logic e,
                      input logic tr, input logic ov, input logic uv,
                      input logic [2:0] bs, input logic [2:0] eh,
                      input logic [2:0] el, input logic efn, input string tag);
    @(negedge clk);
    hi_cmd = h; lo_cmd = l; en = e; trip_in = tr;
    dcbus_ov = ov; vcc_uv = uv; vbs_uv = bs;
    q_cyc.push_back(cyc);
    q_val.push_back({eh, el, efn});
    q_tag.push_back(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset", {hi_out, lo_out, flt_n}, 7'b000_000_1);
    checks++;
    if (flt_oe !== 1'b0) begin errors++; $display("FAIL R11: reset flt_oe=%b expected 0", flt_oe); end
    rst_n = 1'b1;

    // R5 normal drive
    step(3'b001, 3'b010, 1, 0, 0, 0, 3'b000, 3'b001, 3'b010, 1, "R5 normal a");
    step(3'b110, 3'b001, 1, 0, 0, 0, 3'b000, 3'b110, 3'b001, 1, "R5 normal b");
    // R8 shoot-through
    step(3'b011, 3'b001, 1, 0, 0, 0, 3'b000, 3'b010, 3'b000, 1, "R8 both high");
    // R6 enable low
    step(3'b001, 3'b010, 0, 0, 0, 0, 3'b000, 3'b000, 3'b000, 1, "R6 en low");
    step(3'b001, 3'b010, 1, 0, 0, 0, 3'b000, 3'b001, 3'b010, 1, "R6 en not latched");
    // R4 braking, with R10 priority over en
    step(3'b111, 3'b000, 1, 0, 1, 0, 3'b000, 3'b000, 3'b111, 1, "R4 brake");
    step(3'b000, 3'b000, 0, 0, 1, 0, 3'b000, 3'b000, 3'b111, 1, "R4 R10 brake en low");
    step(3'b100, 3'b000, 1, 0, 0, 0, 3'b000, 3'b100, 3'b000, 1, "R4 released");
    // R3 logic undervoltage, R10 over braking
    step(3'b100, 3'b000, 1, 0, 1, 1, 3'b000, 3'b000, 3'b000, 0, "R3 R10 uv over brake");
    step(3'b100, 3'b000, 1, 0, 0, 1, 3'b000, 3'b000, 3'b000, 0, "R3 uv");
    step(3'b100, 3'b000, 1, 0, 0, 0, 3'b000, 3'b100, 3'b000, 1, "R3 not latched");
    // R9 short trip ignored
    for (int i = 0; i < 3; i++)
      step(3'b001, 3'b100, 1, 1, 0, 0, 3'b000, 3'b001, 3'b100, 1, "R9 short trip");
    step(3'b001, 3'b100, 1, 0, 0, 0, 3'b000, 3'b001, 3'b100, 1, "R9 after pulse");
    // R1/R2 qualified trip, hold for clr_delay+2 after release
    for (int i = 1; i <= 4; i++)
      step(3'b001, 3'b100, 1, 1, 0, 0, 3'b000, 3'b001, 3'b100, 1, "R9 blanking");
    for (int i = 5; i <= 8; i++)
      step(3'b001, 3'b100, 1, 1, 0, 0, 3'b000, 3'b000, 3'b000, 0, "R1 trip");
    for (int i = 9; i <= 20; i++)
      step(3'b001, 3'b100, 1, 0, (i == 12), 0, 3'b000, 3'b000, 3'b000, 0,
           (i == 12) ? "R10 hold over brake" : "R2 hold");
    step(3'b001, 3'b100, 1, 0, 0, 0, 3'b000, 3'b001, 3'b100, 1, "R2 released");
    // R7 floating-supply undervoltage
    step(3'b011, 3'b000, 1, 0, 0, 0, 3'b001, 3'b010, 3'b000, 1, "R7 uv phase0");
    step(3'b011, 3'b000, 1, 0, 0, 0, 3'b000, 3'b010, 3'b000, 1, "R7 stays off");
    step(3'b010, 3'b000, 1, 0, 0, 0, 3'b000, 3'b010, 3'b000, 1, "R7 cmd low");
    step(3'b011, 3'b000, 1, 0, 0, 0, 3'b000, 3'b011, 3'b000, 1, "R7 rearmed");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule